// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Zero, Carry and Negative Flags

This unit is the arithmetic engine of a small eight-bit processor. The decoder hands it an eight-bit operation code and two operands. For the register-immediate forms the second operand is simply the immediate value. The unit returns a wrapped eight-bit result, three condition flags, and a write-enable. The write-enable tells the register file whether the destination register must be updated. Compare yields flags only. Division and modulo with a zero divisor raise a fault instead of producing a value.

Most operations finish in one clock: the result, the flags and a one-cycle `done` pulse appear in the cycle after `start`. Unsigned division and modulo use a restoring divider that spends eight iteration steps. While it runs, `busy` is high and new `start` requests are dropped. The flags and the result stay in registers between operations, so conditional branches can read them at any time.

Top module: `alu8_core`

## Requirements
- R1: After a synchronous active-low reset, `result` is 0x00, all three flags are clear, and `done`, `busy`, `rd_write` and `div_zero` are low.
- R2: ADD (0x09), ADDI (0x0A) and INC (0x0D, which adds one and ignores operand B) wrap modulo 256. C is the carry out of bit 7.
- R3: SUB (0x0B), SUBI (0x0C) and DEC (0x0E, which subtracts one) wrap modulo 256. C is the borrow, set when A is below the subtrahend as unsigned values.
- R4: AND (0x0F), OR (0x10), XOR (0x11) and NOT (0x12, which inverts A) clear C.
- R5: CMP (0x13) computes A minus B with the same borrow rule as R3 and updates the flags and `result`, but holds `rd_write` low.
- R6: SHL (0x14) and SHR (0x15) shift logically by B. C is the last bit shifted out, or 0 when B is 0. When B is 8 or more the result is 0x00.
- R7: ROL (0x22) and ROR (0x23) rotate by B modulo 8. C is the bit that wrapped last: result bit 0 for ROL and bit 7 for ROR. C is 0 when B modulo 8 is 0.
- R8: MUL (0x1A) and MULI (0x1B) return the low byte of the unsigned product. C is set when the high byte is non-zero.
- R9: DIV (0x1C, 0x1D) returns the unsigned quotient and MOD (0x1E, 0x1F) the remainder, with C clear. `busy` is high during the eight steps, and `done` is high in the ninth cycle after `start`.
- R10: Division or modulo with B equal to zero gives `done` and `div_zero` in the next cycle with `rd_write` low. `result` and the flags keep their previous values.
- R11: A `start` that arrives while `busy` is high is ignored and produces no extra `done`.
- R12: An opcode outside the set above gives `done` in the next cycle with `rd_write` low. `result` and the flags are unchanged.
- R13: For every completed operation that writes, Z is set exactly when the result is 0x00, and N equals result bit 7.
- R14: Every operation other than a valid division completes with `done` in the cycle after `start`, and with `rd_write` high unless R5, R10 or R12 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation on the current op and operands |
| op | input | 8 | Operation code |
| opnd_a | input | 8 | Destination-side operand |
| opnd_b | input | 8 | Source register value or immediate |
| result | output | 8 | Registered result of the last completed operation |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow / shifted-out flag |
| flag_n | output | 1 | Negative flag (result bit 7) |
| rd_write | output | 1 | Pulse with done: destination register must be written |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Divider is iterating |
| div_zero | output | 1 | Pulse with done: zero divisor fault |

## Verification
The embedded assertions check several rules on every cycle. A divide fault never comes with a write. Compare always completes without a write. Z and N agree with the result whenever a write completes. No completion appears while the divider is mid-iteration. The divider's step counter stays within its range, and a shift by eight or more always yields zero. The bench scenarios are needed for the actual arithmetic values, the carry and borrow choices for each operation, the exact nine-cycle division latency, and the retention of flags across faults and unknown opcodes. They also show that a mid-division reset clears everything.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg
// Purpose : shared opcode constants and the decode record of the ALU.
// Assumes : opcodes are eight bits wide; the values are fixed by the
//           instruction encoding used by the surrounding processor.
package alu8_pkg;

    localparam int OPW = 8;

    localparam logic [OPW-1:0] OPC_ADD  = 8'h09;
    localparam logic [OPW-1:0] OPC_ADDI = 8'h0A;
    localparam logic [OPW-1:0] OPC_SUB  = 8'h0B;
    localparam logic [OPW-1:0] OPC_SUBI = 8'h0C;
    localparam logic [OPW-1:0] OPC_INC  = 8'h0D;
    localparam logic [OPW-1:0] OPC_DEC  = 8'h0E;
    localparam logic [OPW-1:0] OPC_AND  = 8'h0F;
    localparam logic [OPW-1:0] OPC_OR   = 8'h10;
    localparam logic [OPW-1:0] OPC_XOR  = 8'h11;
    localparam logic [OPW-1:0] OPC_NOT  = 8'h12;
    localparam logic [OPW-1:0] OPC_CMP  = 8'h13;
    localparam logic [OPW-1:0] OPC_SHL  = 8'h14;
    localparam logic [OPW-1:0] OPC_SHR  = 8'h15;
    localparam logic [OPW-1:0] OPC_MUL  = 8'h1A;
    localparam logic [OPW-1:0] OPC_MULI = 8'h1B;
    localparam logic [OPW-1:0] OPC_DIV  = 8'h1C;
    localparam logic [OPW-1:0] OPC_DIVI = 8'h1D;
    localparam logic [OPW-1:0] OPC_MOD  = 8'h1E;
    localparam logic [OPW-1:0] OPC_MODI = 8'h1F;
    localparam logic [OPW-1:0] OPC_ROL  = 8'h22;
    localparam logic [OPW-1:0] OPC_ROR  = 8'h23;

    // Which datapath serves an opcode.
    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_ARITH = 2'd1,
        GRP_SHIFT = 2'd2,
        GRP_DIV   = 2'd3
    } grp_e;

    typedef struct packed {
        grp_e grp;     // serving datapath
        logic writes;  // destination register is updated
        logic rem;     // division: return the remainder
    } dec_t;

    // Classify an opcode into its datapath and writeback behaviour.
    function automatic dec_t decode(input logic [OPW-1:0] opc);
        dec_t d;
        d = '{grp: GRP_NONE, writes: 1'b0, rem: 1'b0};
        case (opc)
            OPC_ADD, OPC_ADDI, OPC_SUB, OPC_SUBI, OPC_INC, OPC_DEC,
            OPC_AND, OPC_OR, OPC_XOR, OPC_NOT, OPC_MUL, OPC_MULI: begin
                d.grp    = GRP_ARITH;
                d.writes = 1'b1;
            end
            OPC_CMP: begin
                d.grp    = GRP_ARITH;
                d.writes = 1'b0;
            end
            OPC_SHL, OPC_SHR, OPC_ROL, OPC_ROR: begin
                d.grp    = GRP_SHIFT;
                d.writes = 1'b1;
            end
            OPC_DIV, OPC_DIVI: begin
                d.grp    = GRP_DIV;
                d.writes = 1'b1;
            end
            OPC_MOD, OPC_MODI: begin
                d.grp    = GRP_DIV;
                d.writes = 1'b1;
                d.rem    = 1'b1;
            end
            default: d = '{grp: GRP_NONE, writes: 1'b0, rem: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
// Module alu8_arith
// Purpose : single-cycle add/subtract/logic/multiply datapath.
// Assumes : op is one of the arithmetic-group codes when the output is
//           used; other codes give zero. Carry meaning follows the op:
//           carry-out for add, borrow for subtract and compare,
//           non-zero high half for multiply, zero for logic ops.
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  res,
    output logic           carry
);

    localparam int PW = 2 * DW;

    logic [DW-1:0] addend;
    logic [DW-1:0] subtr;
    logic [DW:0]   sum;
    logic [DW:0]   diff;
    logic [PW-1:0] prod;

    // Pick the second operand of the adder and subtractor.
    always_comb begin
        addend = (op == OPC_INC) ? DW'(1) : b;
        subtr  = (op == OPC_DEC) ? DW'(1) : b;
    end

    // Shared wide adder, subtractor and multiplier.
    always_comb begin
        sum  = {1'b0, a} + {1'b0, addend};
        diff = {1'b0, a} - {1'b0, subtr};
        prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    end

    // Select the result and carry for the operation.
    always_comb begin
        res   = '0;
        carry = 1'b0;
        case (op)
            OPC_ADD, OPC_ADDI, OPC_INC: begin
                res   = sum[DW-1:0];
                carry = sum[DW];
            end
            OPC_SUB, OPC_SUBI, OPC_DEC, OPC_CMP: begin
                res   = diff[DW-1:0];
                carry = diff[DW];
            end
            OPC_AND: res = a & b;
            OPC_OR:  res = a | b;
            OPC_XOR: res = a ^ b;
            OPC_NOT: res = ~a;
            OPC_MUL, OPC_MULI: begin
                res   = prod[DW-1:0];
                carry = |prod[PW-1:DW];
            end
            default: begin
                res   = '0;
                carry = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
// Module alu8_shift
// Purpose : single-cycle logical shifter and rotator.
// Assumes : DW is a power of two so that rotate amounts wrap by taking
//           the low bits of b; shift amounts use all of b, and any
//           amount of DW or more empties the word.
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  res,
    output logic           carry
);

    localparam int CW = $clog2(DW);
    localparam int XW = 2 * DW;

    logic [XW-1:0] left_ext;
    logic [XW-1:0] right_ext;
    logic [XW-1:0] rol_ext;
    logic [XW-1:0] ror_ext;
    logic [CW-1:0] rot_amt;

    // Wide shifts: the bit just past the word is the last one shifted out.
    always_comb begin
        rot_amt   = b[CW-1:0];
        left_ext  = {{DW{1'b0}}, a} << b;
        right_ext = {a, {DW{1'b0}}} >> b;
        rol_ext   = {a, a} << rot_amt;
        ror_ext   = {a, a} >> rot_amt;
    end

    // Select the result and the shifted-out bit.
    always_comb begin
        res   = '0;
        carry = 1'b0;
        case (op)
            OPC_SHL: begin
                res   = left_ext[DW-1:0];
                carry = left_ext[DW];
            end
            OPC_SHR: begin
                res   = right_ext[XW-1:DW];
                carry = right_ext[DW-1];
            end
            OPC_ROL: begin
                res   = rol_ext[XW-1:DW];
                carry = (rot_amt != '0) ? rol_ext[DW] : 1'b0;
            end
            OPC_ROR: begin
                res   = ror_ext[DW-1:0];
                carry = (rot_amt != '0) ? ror_ext[DW-1] : 1'b0;
            end
            default: begin
                res   = '0;
                carry = 1'b0;
            end
        endcase
    end

    // Guard: a logical shift by the word width or more leaves nothing.
    always_comb begin
        if ((op == OPC_SHL || op == OPC_SHR) && (b >= DW[DW-1:0]))
            assert_shift_clears_R6: assert (res == '0);
    end

endmodule

// File: rtl/alu8_divider.sv
// Module alu8_divider
// Purpose : unsigned restoring divider, one quotient bit per clock.
// Assumes : load is raised only when busy is low and divisor is non-zero;
//           quo_next/rem_next hold the final answer in the cycle last is
//           high, so the caller can register them on that edge.
module alu8_divider #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          last,
    output logic [DW-1:0] quo_next,
    output logic [DW-1:0] rem_next
);

    localparam int CNTW = $clog2(DW + 1);

    logic            busy_q;
    logic [CNTW-1:0] cnt_q;
    logic [DW-1:0]   quo_q;
    logic [DW-1:0]   rem_q;
    logic [DW-1:0]   dvs_q;
    logic [DW:0]     trial;
    logic [DW:0]     trial_sub;
    logic            fits;

    // One restoring step: bring in the next dividend bit, try to subtract.
    always_comb begin
        trial     = {rem_q, quo_q[DW-1]};
        trial_sub = trial - {1'b0, dvs_q};
        fits      = (trial >= {1'b0, dvs_q});
        rem_next  = fits ? trial_sub[DW-1:0] : trial[DW-1:0];
        quo_next  = {quo_q[DW-2:0], fits};
        last      = busy_q && (cnt_q == CNTW'(1));
        busy      = busy_q;
    end

    // Iteration state: load operands, then step until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= CNTW'(DW);
            quo_q  <= dividend;
            rem_q  <= '0;
            dvs_q  <= divisor;
        end else if (busy_q) begin
            quo_q <= quo_next;
            rem_q <= rem_next;
            cnt_q <= cnt_q - CNTW'(1);
            if (last)
                busy_q <= 1'b0;
        end
    end

    // R9: the step counter stays within 1..DW while iterating.
    assert_count_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0) && (cnt_q <= CNTW'(DW)));

    // R9: the final step ends the busy period.
    assert_last_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy_q);

    // R10: a zero divisor never reaches the iterator.
    assert_no_zero_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (divisor != '0));

endmodule

// File: rtl/alu8_core.sv
// Module alu8_core
// Purpose : top of the eight-bit ALU; accepts an operation on start,
//           completes single-cycle ops on the next edge and division or
//           modulo after eight divider steps, and keeps the result and
//           Z/C/N flags in registers.
// Assumes : start is a request qualified only by busy; while busy is high
//           new requests are dropped. Faults and unknown opcodes leave
//           result and flags untouched.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  opnd_a,
    input  logic [DW-1:0]  opnd_b,
    output logic [DW-1:0]  result,
    output logic           flag_z,
    output logic           flag_c,
    output logic           flag_n,
    output logic           rd_write,
    output logic           done,
    output logic           busy,
    output logic           div_zero
);

    dec_t          dec;
    logic          accept;
    logic          div_load;
    logic [DW-1:0] ar_res;
    logic          ar_c;
    logic [DW-1:0] sh_res;
    logic          sh_c;
    logic [DW-1:0] one_res;
    logic          one_c;
    logic          div_busy;
    logic          div_last;
    logic [DW-1:0] div_quo;
    logic [DW-1:0] div_rem;
    logic          want_rem_q;

    // Decode the request and decide whether it is taken this cycle.
    always_comb begin
        dec      = decode(op);
        accept   = start && !div_busy;
        div_load = accept && (dec.grp == GRP_DIV) && (opnd_b != '0);
        busy     = div_busy;
    end

    alu8_arith #(.DW(DW)) u_arith (
        .op    (op),
        .a     (opnd_a),
        .b     (opnd_b),
        .res   (ar_res),
        .carry (ar_c)
    );

    alu8_shift #(.DW(DW)) u_shift (
        .op    (op),
        .a     (opnd_a),
        .b     (opnd_b),
        .res   (sh_res),
        .carry (sh_c)
    );

    alu8_divider #(.DW(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (opnd_a),
        .divisor  (opnd_b),
        .busy     (div_busy),
        .last     (div_last),
        .quo_next (div_quo),
        .rem_next (div_rem)
    );

    // Merge the two single-cycle datapaths.
    always_comb begin
        one_res = (dec.grp == GRP_SHIFT) ? sh_res : ar_res;
        one_c   = (dec.grp == GRP_SHIFT) ? sh_c   : ar_c;
    end

    // Remember whether the running division returns the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)
            want_rem_q <= 1'b0;
        else if (div_load)
            want_rem_q <= dec.rem;
    end

    // Result, flag and completion registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            flag_z   <= 1'b0;
            flag_c   <= 1'b0;
            flag_n   <= 1'b0;
            rd_write <= 1'b0;
            done     <= 1'b0;
            div_zero <= 1'b0;
        end else begin
            rd_write <= 1'b0;
            done     <= 1'b0;
            div_zero <= 1'b0;
            if (div_last) begin
                result   <= want_rem_q ? div_rem : div_quo;
                flag_z   <= (want_rem_q ? div_rem : div_quo) == '0;
                flag_n   <= want_rem_q ? div_rem[DW-1] : div_quo[DW-1];
                flag_c   <= 1'b0;
                rd_write <= 1'b1;
                done     <= 1'b1;
            end else if (accept) begin
                case (dec.grp)
                    GRP_ARITH, GRP_SHIFT: begin
                        result   <= one_res;
                        flag_z   <= (one_res == '0);
                        flag_n   <= one_res[DW-1];
                        flag_c   <= one_c;
                        rd_write <= dec.writes;
                        done     <= 1'b1;
                    end
                    GRP_DIV: begin
                        if (opnd_b == '0) begin
                            div_zero <= 1'b1;
                            done     <= 1'b1;
                        end
                    end
                    default: done <= 1'b1;
                endcase
            end
        end
    end

    // R10: a divide fault is a completion that never writes.
    assert_fault_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (done && !rd_write));

    // R5: an accepted compare completes next cycle without a write.
    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OPC_CMP) |=> (done && !rd_write));

    // R13: Z agrees with the written result.
    assert_zero_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_write) |-> (flag_z == (result == '0)));

    // R13: N agrees with the top bit of the written result.
    assert_neg_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_write) |-> (flag_n == result[DW-1]));

    // R11: no completion can appear while the divider is mid-iteration.
    assert_busy_blocks_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && !div_last) |=> !done);

    // R9: the divider's final step always produces a writing completion.
    assert_div_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_last |=> (done && rd_write && !div_zero));

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] op = 8'h00;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [7:0] result;
    logic       flag_z, flag_c, flag_n, rd_write, done, busy, div_zero;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n),
        .rd_write(rd_write), .done(done), .busy(busy), .div_zero(div_zero)
    );

    // Vector: {op, a, b, expected result, expected C, expected write}
    localparam int NV = 29;
    localparam logic [33:0] VEC [NV] = '{
        {8'h09, 8'h70, 8'h20, 8'h90, 1'b0, 1'b1},  // R2 add, negative
        {8'h09, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},  // R2 add wraps
        {8'h0A, 8'h10, 8'h05, 8'h15, 1'b0, 1'b1},  // R2 addi
        {8'h0B, 8'h05, 8'h07, 8'hFE, 1'b1, 1'b1},  // R3 sub borrow
        {8'h0C, 8'h07, 8'h07, 8'h00, 1'b0, 1'b1},  // R3 subi zero
        {8'h0D, 8'hFF, 8'h33, 8'h00, 1'b1, 1'b1},  // R2 inc ignores B
        {8'h0E, 8'h00, 8'h44, 8'hFF, 1'b1, 1'b1},  // R3 dec underflow
        {8'h0F, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b1},  // R4 and
        {8'h10, 8'hF0, 8'h0C, 8'hFC, 1'b0, 1'b1},  // R4 or
        {8'h11, 8'hFF, 8'h0F, 8'hF0, 1'b0, 1'b1},  // R4 xor
        {8'h12, 8'h5A, 8'h00, 8'hA5, 1'b0, 1'b1},  // R4 not
        {8'h13, 8'h03, 8'h04, 8'hFF, 1'b1, 1'b0},  // R5 cmp less
        {8'h13, 8'h09, 8'h09, 8'h00, 1'b0, 1'b0},  // R5 cmp equal
        {8'h14, 8'h81, 8'h01, 8'h02, 1'b1, 1'b1},  // R6 shl 1
        {8'h14, 8'h81, 8'h08, 8'h00, 1'b1, 1'b1},  // R6 shl 8
        {8'h14, 8'h81, 8'h09, 8'h00, 1'b0, 1'b1},  // R6 shl 9
        {8'h15, 8'h81, 8'h01, 8'h40, 1'b1, 1'b1},  // R6 shr 1
        {8'h15, 8'h81, 8'h00, 8'h81, 1'b0, 1'b1},  // R6 shr 0
        {8'h22, 8'h81, 8'h01, 8'h03, 1'b1, 1'b1},  // R7 rol 1
        {8'h22, 8'h81, 8'h09, 8'h03, 1'b1, 1'b1},  // R7 rol 9 = rol 1
        {8'h23, 8'h01, 8'h01, 8'h80, 1'b1, 1'b1},  // R7 ror 1
        {8'h23, 8'h96, 8'h08, 8'h96, 1'b0, 1'b1},  // R7 ror 8 = none
        {8'h1A, 8'h10, 8'h10, 8'h00, 1'b1, 1'b1},  // R8 mul overflow
        {8'h1B, 8'h07, 8'h03, 8'h15, 1'b0, 1'b1},  // R8 muli
        {8'h1C, 8'hC8, 8'h07, 8'h1C, 1'b0, 1'b1},  // R9 div
        {8'h1D, 8'hFF, 8'h01, 8'hFF, 1'b0, 1'b1},  // R9 divi by one
        {8'h1E, 8'hC8, 8'h07, 8'h04, 1'b0, 1'b1},  // R9 mod
        {8'h1F, 8'h05, 8'h09, 8'h05, 1'b0, 1'b1},  // R9 modi small
        {8'h1C, 8'h03, 8'hFF, 8'h00, 1'b0, 1'b1}   // R9 div to zero
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Issue one request and count cycles until done (1 = next cycle).
    task automatic issue(input logic [7:0] o, input logic [7:0] a,
                         input logic [7:0] b, output int lat);
        @(negedge clk);
        start = 1'b1; op = o; opnd_a = a; opnd_b = b;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        if (!finished) begin
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [7:0] keep_res;
        logic [2:0] keep_flags;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(result == 8'h00, "R1 result", result, 0);
        check({flag_z, flag_c, flag_n} == 3'b000, "R1 flags", {flag_z, flag_c, flag_n}, 0);
        check({done, busy, rd_write, div_zero} == 4'b0000, "R1 status",
              {done, busy, rd_write, div_zero}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [7:0] vo, va, vb, vr;
            logic vc, vw;
            int exp_lat;
            {vo, va, vb, vr, vc, vw} = VEC[i];
            exp_lat = (vo >= 8'h1C && vo <= 8'h1F) ? 9 : 1;
            issue(vo, va, vb, lat);
            check(lat == exp_lat, $sformatf("R14/R9 latency op %0h", vo), lat, exp_lat);
            check(result == vr, $sformatf("R2-table result op %0h", vo), result, vr);
            check(flag_c == vc, $sformatf("carry op %0h", vo), flag_c, vc);
            check(flag_z == (vr == 8'h00), $sformatf("R13 zero op %0h", vo), flag_z, vr == 8'h00);
            check(flag_n == vr[7], $sformatf("R13 neg op %0h", vo), flag_n, vr[7]);
            check(rd_write == vw, $sformatf("R5/R14 write op %0h", vo), rd_write, vw);
            check(div_zero == 1'b0, $sformatf("R10 no fault op %0h", vo), div_zero, 0);
        end

        // R9 busy during iteration
        @(negedge clk);
        start = 1'b1; op = 8'h1C; opnd_a = 8'hC8; opnd_b = 8'h07;
        @(negedge clk);
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        // R11 start while busy ignored
        op = 8'h09; opnd_a = 8'h01; opnd_b = 8'h01;
        repeat (3) @(negedge clk);
        start = 1'b0;
        lat = 4;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 9, "R11 division latency unchanged", lat, 9);
        check(result == 8'h1C, "R11 division result", result, 8'h1C);
        @(negedge clk);
        check(done == 1'b0 && result == 8'h1C, "R11 no extra completion", {done, result}, 8'h1C);

        // R10 divide and modulo by zero keep result and flags
        issue(8'h0B, 8'h05, 8'h07, lat);  // result FE, C=1, N=1
        keep_res = result; keep_flags = {flag_z, flag_c, flag_n};
        issue(8'h1C, 8'h40, 8'h00, lat);
        check(lat == 1, "R10 fault latency", lat, 1);
        check(div_zero == 1'b1 && rd_write == 1'b0, "R10 fault pulse", {div_zero, rd_write}, 2);
        check(result == keep_res, "R10 result held", result, keep_res);
        check({flag_z, flag_c, flag_n} == keep_flags, "R10 flags held",
              {flag_z, flag_c, flag_n}, keep_flags);
        issue(8'h1F, 8'h40, 8'h00, lat);
        check(div_zero == 1'b1 && lat == 1, "R10 modi zero fault", {div_zero, lat}, 9'h101);
        @(negedge clk);
        check(div_zero == 1'b0 && busy == 1'b0, "R10 fault one cycle", div_zero, 0);

        // R12 unknown opcode
        issue(8'h05, 8'h00, 8'h00, lat);
        check(lat == 1 && rd_write == 1'b0, "R12 done without write", {lat, rd_write}, 2);
        check(result == keep_res, "R12 result held", result, keep_res);
        check({flag_z, flag_c, flag_n} == keep_flags, "R12 flags held",
              {flag_z, flag_c, flag_n}, keep_flags);

        // R1 reset during division
        @(negedge clk);
        start = 1'b1; op = 8'h1E; opnd_a = 8'h77; opnd_b = 8'h05;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({busy, done, result} == 10'h0, "R1 mid-division reset", {busy, done, result}, 0);
        check({flag_z, flag_c, flag_n} == 3'b000, "R1 flags after reset", {flag_z, flag_c, flag_n}, 0);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R1 aborted division stays quiet", {done, busy}, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule